// File: doc/BRIEF.md
# Grouped GPIO Interrupt Combiner

This block watches a bank of general-purpose input pins and turns them into a small number of group interrupt lines, two by default. Each group has its own membership mask and its own polarity mask. A member pin counts as active when its level matches its polarity bit. The active members are then reduced to one group condition, either by OR (any member active) or by AND (every member active). An AND group with no members never asserts.

Each group chooses between two trigger behaviours. In level mode its interrupt line follows the group condition. In edge mode a rising edge of the condition sets a sticky pending flag, and the line follows that flag until software writes 1 to clear it. A per-group interrupt enable gates the line. An initialize command removes every member from a group, disables its interrupt and drops any pending flag, all in one write.

The pin bank passes through a shared two-stage synchronizer before any group logic sees it. Software reaches every group through one flat register port. The group number is in the upper address bits and a two-bit register offset is in the lower bits. Reads are combinational from the address.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset every group register reads 0 and every interrupt line is low.
- R2: A pin whose membership bit (offset 1, bit i for pin i) is 0 has no effect on its group's condition.
- R3: A member pin is active when its level equals its polarity bit (offset 2): 1 means active high and 0 means active low.
- R4: With control bit 0 clear (OR mode), the group condition is true when at least one member pin is active.
- R5: With control bit 0 set (AND mode), the group condition is true when every member pin is active.
- R6: In AND mode a group whose membership mask is zero never raises its condition.
- R7: With control bit 1 clear (level mode) and the enable set, the interrupt line equals the group condition. A pin change first shows on the line at the third rising clock edge after it is applied, and not at the second.
- R8: With control bit 1 set (edge mode), a rising edge of the condition sets the pending flag (status bit 1). The line stays high while the flag is set, even after the condition falls. Writing status with bit 1 set clears the flag, and writing it with bit 1 clear leaves the flag unchanged.
- R9: With control bit 2 (enable) clear, the interrupt line stays low, while status bit 0 still reports the live condition.
- R10: A control write with bit 3 set clears the membership mask, the enable bit and the pending flag. It takes the mode bits 0 and 1 from the same write and leaves the polarity mask unchanged. Bit 3 reads back as 0.
- R11: Groups are independent. Writes that address one group (address bit 2 selects the group, bits 1:0 the offset: 0 control, 1 membership, 2 polarity, 3 status) leave the other group's registers and interrupt line unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | N_PINS | Asynchronous GPIO input bank |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Group number above a two-bit register offset |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data for addr_i |
| irq_o | output | N_GROUPS | Per-group interrupt lines |

## Verification
The reduction is tried with sparse, dense and empty membership masks, under both polarities, with pin patterns that either equal the polarity mask or differ from it at random. This separates the OR reduction from the AND reduction and shows whether non-member pins leak into the result. Directed patterns toggle only non-member pins, flip a single member's level against its polarity, and drive an empty AND group to all-active. Edge mode is tried with a pulse on the condition followed by clear writes with and without the clear bit, and a single pin step is timed edge by edge to pin the synchronizer latency.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

    localparam int OFS_W = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL   = 2'd0,
        OFS_MEMBER = 2'd1,
        OFS_POLAR  = 2'd2,
        OFS_STATUS = 2'd3
    } ofs_e;

    // control register fields
    localparam int CTRL_AND_BIT  = 0;
    localparam int CTRL_EDGE_BIT = 1;
    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_INIT_BIT = 3;

    // status register fields
    localparam int STAT_COND_BIT = 0;
    localparam int STAT_FLAG_BIT = 1;

endpackage

// File: rtl/gpio_grp_sync.sv
module gpio_grp_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stage2;

endmodule

// File: rtl/gpio_grp_unit.sv
module gpio_grp_unit
    import gpio_grp_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_i,
    input  logic              wr_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [N_PINS-1:0] wdata_i,
    output logic [N_PINS-1:0] member_o,
    output logic [N_PINS-1:0] polar_o,
    output logic              and_o,
    output logic              edge_o,
    output logic              en_o,
    output logic              cond_o,
    output logic              flag_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [N_PINS-1:0] member;
        logic [N_PINS-1:0] polar;
        logic              and_mode;
        logic              edge_mode;
        logic              irq_en;
        logic              cond;
        logic              flag;
    } grp_t;

    grp_t grp_d, grp_q;

    logic [N_PINS-1:0] active;
    logic              or_term;
    logic              and_term;
    logic              cond_now;
    logic              rise;
    logic              do_init;
    logic              do_clr;

    always_comb begin
        active   = ~(pins_i ^ grp_q.polar);
        or_term  = |(active & grp_q.member);
        // an empty AND group is held false
        and_term = (&(active | ~grp_q.member)) & (|grp_q.member);
        cond_now = grp_q.and_mode ? and_term : or_term;
        rise     = cond_now & ~grp_q.cond;
        do_init  = wr_i && (ofs_i == OFS_CTRL) && wdata_i[CTRL_INIT_BIT];
        do_clr   = wr_i && (ofs_i == OFS_STATUS) && wdata_i[STAT_FLAG_BIT];

        grp_d      = grp_q;
        grp_d.cond = cond_now;

        if (wr_i) begin
            case (ofs_e'(ofs_i))
                OFS_CTRL: begin
                    grp_d.and_mode  = wdata_i[CTRL_AND_BIT];
                    grp_d.edge_mode = wdata_i[CTRL_EDGE_BIT];
                    grp_d.irq_en    = wdata_i[CTRL_EN_BIT];
                end
                OFS_MEMBER: grp_d.member = wdata_i;
                OFS_POLAR:  grp_d.polar  = wdata_i;
                default: ;
            endcase
        end

        // priority: init, then a new rising edge, then a software clear
        if (do_clr) begin
            grp_d.flag = 1'b0;
        end
        if (rise) begin
            grp_d.flag = 1'b1;
        end
        if (do_init) begin
            grp_d.member = '0;
            grp_d.irq_en = 1'b0;
            grp_d.flag   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign member_o = grp_q.member;
    assign polar_o  = grp_q.polar;
    assign and_o    = grp_q.and_mode;
    assign edge_o   = grp_q.edge_mode;
    assign en_o     = grp_q.irq_en;
    assign cond_o   = grp_q.cond;
    assign flag_o   = grp_q.flag;
    assign irq_o    = grp_q.irq_en & (grp_q.edge_mode ? grp_q.flag : grp_q.cond);

endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
    import gpio_grp_pkg::*;
#(
    parameter int  N_PINS   = 8,
    parameter int  N_GROUPS = 2,
    parameter int  DATA_W   = 32,
    localparam int GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int ADDR_W   = OFS_W + GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PINS-1:0]   pins_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [N_GROUPS-1:0] irq_o
);

    logic [N_PINS-1:0]               pins_s;
    logic [GRP_W-1:0]                addr_grp;
    ofs_e                            addr_ofs;

    logic [N_GROUPS-1:0][N_PINS-1:0] grp_member;
    logic [N_GROUPS-1:0][N_PINS-1:0] grp_polar;
    logic [N_GROUPS-1:0]             grp_and;
    logic [N_GROUPS-1:0]             grp_edge;
    logic [N_GROUPS-1:0]             grp_en;
    logic [N_GROUPS-1:0]             grp_cond;
    logic [N_GROUPS-1:0]             grp_flag;

    assign addr_grp = addr_i[ADDR_W-1:OFS_W];
    assign addr_ofs = ofs_e'(addr_i[OFS_W-1:0]);

    gpio_grp_sync #(
        .WIDTH (N_PINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (pins_s)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic wr_hit;
        assign wr_hit = wr_en_i && (addr_grp == GRP_W'(g));

        gpio_grp_unit #(
            .N_PINS (N_PINS)
        ) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins_i   (pins_s),
            .wr_i     (wr_hit),
            .ofs_i    (addr_i[OFS_W-1:0]),
            .wdata_i  (wdata_i[N_PINS-1:0]),
            .member_o (grp_member[g]),
            .polar_o  (grp_polar[g]),
            .and_o    (grp_and[g]),
            .edge_o   (grp_edge[g]),
            .en_o     (grp_en[g]),
            .cond_o   (grp_cond[g]),
            .flag_o   (grp_flag[g]),
            .irq_o    (irq_o[g])
        );
    end

    if (DATA_W > N_PINS) begin : g_wide
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_PINS];
    end

    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (addr_grp == GRP_W'(g)) begin
                case (addr_ofs)
                    OFS_CTRL: begin
                        rdata_o[CTRL_AND_BIT]  = grp_and[g];
                        rdata_o[CTRL_EDGE_BIT] = grp_edge[g];
                        rdata_o[CTRL_EN_BIT]   = grp_en[g];
                    end
                    OFS_MEMBER: rdata_o[N_PINS-1:0] = grp_member[g];
                    OFS_POLAR:  rdata_o[N_PINS-1:0] = grp_polar[g];
                    OFS_STATUS: begin
                        rdata_o[STAT_COND_BIT] = grp_cond[g];
                        rdata_o[STAT_FLAG_BIT] = grp_flag[g];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_grp_chk.sv
module gpio_grp_chk
    import gpio_grp_pkg::*;
#(
    parameter int  N_PINS   = 8,
    parameter int  N_GROUPS = 2,
    parameter int  DATA_W   = 32,
    localparam int GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int ADDR_W   = OFS_W + GRP_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en_i,
    input logic [ADDR_W-1:0]               addr_i,
    input logic [DATA_W-1:0]               wdata_i,
    input logic [N_GROUPS-1:0]             irq_o,
    input logic [N_GROUPS-1:0][N_PINS-1:0] grp_member,
    input logic [N_GROUPS-1:0]             grp_en,
    input logic [N_GROUPS-1:0]             grp_cond,
    input logic [N_GROUPS-1:0]             grp_flag
);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
        logic hit_grp;
        logic hit_init;
        logic hit_clr;

        assign hit_grp  = wr_en_i && (addr_i[ADDR_W-1:OFS_W] == GRP_W'(g));
        assign hit_init = hit_grp && (addr_i[OFS_W-1:0] == OFS_CTRL) && wdata_i[CTRL_INIT_BIT];
        assign hit_clr  = hit_grp && (addr_i[OFS_W-1:0] == OFS_STATUS) && wdata_i[STAT_FLAG_BIT];

        // R9: a line is only high while its group is enabled
        a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |-> grp_en[g]);

        // R6: an empty group never yields a true condition
        a_r6_empty_never_true: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_member[g] == '0) |=> !grp_cond[g]);

        // R8: pending flag is sticky until cleared or initialized
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_flag[g] && !hit_clr && !hit_init) |=> grp_flag[g]);

        // R8: a rising condition always leaves the flag set
        a_r8_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(grp_cond[g]) && !$past(hit_init)) |-> grp_flag[g]);

        // R10: initialize empties and disables the group
        a_r10_init_empties: assert property (@(posedge clk) disable iff (!rst_n)
            hit_init |=> (grp_member[g] == '0 && !grp_en[g] && !grp_flag[g]));
    end

endmodule

bind gpio_grp_irq gpio_grp_chk #(
    .N_PINS   (N_PINS),
    .N_GROUPS (N_GROUPS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .irq_o      (irq_o),
    .grp_member (grp_member),
    .grp_en     (grp_en),
    .grp_cond   (grp_cond),
    .grp_flag   (grp_flag)
);

// File: tb/tb_gpio_grp_irq.sv
module tb_gpio_grp_irq;

    localparam int NP = 8;
    localparam int NG = 2;
    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [NG-1:0] irq;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_grp_irq #(
        .N_PINS   (NP),
        .N_GROUPS (NG),
        .DATA_W   (DW)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int g, input int ofs, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = {g[0], ofs[1:0]};
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic rd(input int g, input int ofs, output logic [DW-1:0] d);
        addr = {g[0], ofs[1:0]};
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic cond_model(input logic [NP-1:0] p, input logic [NP-1:0] m,
                                        input logic [NP-1:0] pol, input logic and_m);
        logic [NP-1:0] act;
        act = ~(p ^ pol);
        if (and_m) return (m != '0) && ((act | ~m) == '1);
        return |(act & m);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [NP-1:0] rm [NG];
        logic [NP-1:0] rp [NG];
        logic          ra [NG];

        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        pins  = '0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {30'd0, irq}, 0);
        for (int g = 0; g < NG; g++) begin
            for (int o = 0; o < 4; o++) begin
                rd(g, o, d);
                check($sformatf("R1 reg g%0d o%0d", g, o), d, 0);
            end
        end

        // R7: level mode latency through the synchronizer
        wr(0, 2, 32'h01);
        wr(0, 1, 32'h01);
        wr(0, 0, 32'h4);
        settle();
        check("R7 idle low", irq[0], 0);
        @(negedge clk); pins = 8'h01;
        @(negedge clk);
        @(negedge clk);
        check("R7 not after two edges", irq[0], 0);
        @(negedge clk);
        check("R7 visible after three edges", irq[0], 1);

        // R3: active-low member
        wr(0, 2, 32'h00);
        settle();
        check("R3 high pin inactive when polarity 0", irq[0], 0);
        pins = 8'h00;
        settle();
        check("R3 low pin active when polarity 0", irq[0], 1);

        // R2: non-member pins toggle without effect
        wr(0, 2, 32'h01);
        pins = 8'hFE;
        settle();
        check("R2 non-members ignored in OR", irq[0], 0);
        pins = 8'h00;
        settle();
        check("R2 non-members ignored again", irq[0], 0);

        // R4: OR reduction
        wr(0, 1, 32'h0F);
        wr(0, 2, 32'hFF);
        pins = 8'h04;
        settle();
        check("R4 one member active", irq[0], 1);
        pins = 8'hF0;
        settle();
        check("R4 no member active", irq[0], 0);

        // R5: AND reduction
        wr(0, 0, 32'h5);
        wr(0, 2, 32'h0F);
        pins = 8'h0F;
        settle();
        check("R5 all members active", irq[0], 1);
        pins = 8'h07;
        settle();
        check("R5 one member inactive", irq[0], 0);
        pins = 8'hAF;
        settle();
        check("R5 non-members ignored in AND", irq[0], 1);

        // R6: empty AND group
        wr(0, 1, 32'h00);
        wr(0, 2, 32'hFF);
        pins = 8'hFF;
        settle();
        check("R6 empty AND irq", irq[0], 0);
        rd(0, 3, d);
        check("R6 empty AND status cond", d[0], 0);

        // R9: enable gates the line, status still live
        wr(0, 0, 32'h1);
        wr(0, 1, 32'h03);
        wr(0, 2, 32'h03);
        pins = 8'h03;
        settle();
        check("R9 disabled line low", irq[0], 0);
        rd(0, 3, d);
        check("R9 status cond live", d[0], 1);

        // R8: edge mode pending flag
        wr(0, 0, 32'h6);
        wr(0, 1, 32'h01);
        wr(0, 2, 32'h01);
        pins = 8'h00;
        settle();
        wr(0, 3, 32'h2);
        settle();
        check("R8 cleared before pulse", irq[0], 0);
        pins = 8'h01;
        settle();
        check("R8 rise sets line", irq[0], 1);
        rd(0, 3, d);
        check("R8 status cond+flag", d[1:0], 2'b11);
        pins = 8'h00;
        settle();
        check("R8 line held after condition falls", irq[0], 1);
        rd(0, 3, d);
        check("R8 status flag only", d[1:0], 2'b10);
        wr(0, 3, 32'h1);
        settle();
        check("R8 write without clear bit keeps flag", irq[0], 1);
        wr(0, 3, 32'h2);
        settle();
        check("R8 clear write drops line", irq[0], 0);
        rd(0, 3, d);
        check("R8 status after clear", d[1:0], 2'b00);

        // R10: initialize
        pins = 8'h01;
        settle();
        check("R10 flag set before init", irq[0], 1);
        wr(0, 0, 32'hD);
        settle();
        rd(0, 0, d);
        check("R10 ctrl after init", d, 32'h1);
        rd(0, 1, d);
        check("R10 members cleared", d, 0);
        rd(0, 2, d);
        check("R10 polarity kept", d, 32'h01);
        rd(0, 3, d);
        check("R10 flag cleared", d[1], 0);
        check("R10 line low", irq[0], 0);

        // R11: group independence
        wr(1, 0, 32'h4);
        wr(1, 1, 32'hF0);
        wr(1, 2, 32'h00);
        pins = 8'h0F;
        settle();
        check("R11 group1 fires", irq[1], 1);
        check("R11 group0 unaffected", irq[0], 0);
        rd(0, 0, d);
        check("R11 group0 ctrl unchanged", d, 32'h1);
        rd(0, 2, d);
        check("R11 group0 polarity unchanged", d, 32'h01);

        // R4 R5 R11: random level-mode configurations on both groups
        for (int it = 0; it < 60; it++) begin
            for (int g = 0; g < NG; g++) begin
                ra[g] = 1'($urandom % 2);
                rm[g] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
                rp[g] = 8'($urandom);
                wr(g, 0, {29'd0, 1'b1, 1'b0, ra[g]});
                wr(g, 1, {24'd0, rm[g]});
                wr(g, 2, {24'd0, rp[g]});
            end
            case ($urandom % 3)
                0:       pins = rp[0];
                1:       pins = rp[1];
                default: pins = 8'($urandom);
            endcase
            settle();
            for (int g = 0; g < NG; g++) begin
                check($sformatf("R4/R5 random it%0d g%0d irq", it, g), irq[g],
                      cond_model(pins, rm[g], rp[g], ra[g]));
                rd(g, 3, d);
                check($sformatf("R11 random it%0d g%0d status", it, g), d[0],
                      cond_model(pins, rm[g], rp[g], ra[g]));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule